// File: doc/BRIEF.md
# Early/Late Binary Phase Detector with Sampler Role Swap

This block is the phase sensor of a clock-and-data recovery loop. It samples a serial bit stream on both edges of the recovered clock. One edge gives a data sample, the other gives a sample taken at the expected bit boundary. Each decision uses three samples: the previous data bit, the boundary sample, and the current data bit. The block reports only the sign of the phase error. It raises `up` when the recovered clock is early, raises `dn` when it is late, and keeps both low when the data did not change. All outputs are registered on the rising clock edge.

When the loop gets stuck at the end of its delay range, the control logic can flip `swap_mode`. This makes the falling edge take the data samples and the rising edge take the boundary samples. The effect is the same as moving the detector's transfer curve by half a unit interval. After each mode change, both outputs stay low for two cycles, so that decisions built from samples of the old mode never reach the loop filter. The recovered bit `rdata` comes from whichever edge is currently taking data samples.

Top module: `bbpd_swap`

## Requirements
- R1: While `rst_n` is low, `up`, `dn` and `rdata` are 0.
- R2: With `swap_mode` at 0, the rising edge samples data and the falling edge samples the boundary. The window is prev = rising sample at edge p-1, boundary = falling sample between edges p-1 and p, cur = rising sample at edge p. The outputs for this window appear after rising edge p+1, and `rdata` then equals cur.
- R3: If prev equals cur, both `up` and `dn` are 0.
- R4: If prev differs from cur and the boundary sample equals prev (clock early), `up` is 1 and `dn` is 0.
- R5: If prev differs from cur and the boundary sample equals cur (clock late), `dn` is 1 and `up` is 0.
- R6: `up` and `dn` are never 1 in the same cycle.
- R7: With `swap_mode` at 1, the falling edge samples data and the rising edge samples the boundary. The window is prev = falling sample before edge p-1, boundary = rising sample at edge p-1, cur = falling sample before edge p. The outputs appear after edge p+1, and `rdata` equals cur.
- R8: Take the rising edge at which the sampled `swap_mode` differs from its value at the previous edge. The `up` and `dn` values registered at that edge and at the next one are 0. `rdata` keeps following R2/R7 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; both edges sample data |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial data stream |
| swap_mode | input | 1 | 0: rising edge samples data; 1: falling edge samples data |
| up | output | 1 | Clock early: move the sampling phase later |
| dn | output | 1 | Clock late: move the sampling phase earlier |
| rdata | output | 1 | Recovered data bit |

## Verification
Each rising edge closes a sample window, and the decision and recovered bit for that window are registered at the following rising edge. The window therefore shows at the ports one full clock after its last sample. The bench keeps queues of the samples seen on each edge. At every rising edge it works out the result for the window that ended one edge earlier, and it compares that result with the outputs 2 ns after that edge. A mode change is applied in the model at the edge where the new `swap_mode` is first sampled, and it blanks that edge's and the next edge's decisions.

// File: rtl/bbpd_swap.sv
`timescale 1ns/1ps
module bbpd_swap (
  input  logic clk,
  input  logic rst_n,
  input  logic sdata,
  input  logic swap_mode,
  output logic up,
  output logic dn,
  output logic rdata
);
  logic fall_s;
  logic r0, r1, f0, f1;
  logic mode_q, hold;
  logic chg, quiet, prev, edg, cur, moved;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_s <= 1'b0;
    else        fall_s <= sdata;

  assign chg   = swap_mode ^ mode_q;
  assign quiet = chg | hold;
  assign prev  = mode_q ? f1 : r1;
  assign edg   = mode_q ? r1 : f0;
  assign cur   = mode_q ? f0 : r0;
  assign moved = prev ^ cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0 <= 1'b0; r1 <= 1'b0; f0 <= 1'b0; f1 <= 1'b0;
      mode_q <= 1'b0; hold <= 1'b0;
      up <= 1'b0; dn <= 1'b0; rdata <= 1'b0;
    end else begin
      r0 <= sdata;
      r1 <= r0;
      f0 <= fall_s;
      f1 <= f0;
      mode_q <= swap_mode;
      hold <= chg;
      rdata <= cur;
      up <= !quiet && moved && (edg == prev);
      dn <= !quiet && moved && (edg == cur);
    end
  end
endmodule

module bbpd_swap_chk (
  input logic clk,
  input logic rst_n,
  input logic swap_mode,
  input logic up,
  input logic dn,
  input logic rdata
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!up && !dn && !rdata)); // R1
  AST_NO_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == $past(rdata)) |-> (!up && !dn)); // R3
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn)); // R6
  AST_SWAP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_mode != $past(swap_mode)) |=> (!up && !dn) ##1 (!up && !dn)); // R8
endmodule

bind bbpd_swap bbpd_swap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .swap_mode(swap_mode),
  .up(up), .dn(dn), .rdata(rdata)
);

// File: tb/bbpd_swap_bench.sv
`timescale 1ns/1ps
module bbpd_swap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic swap_mode = 1'b0;
  logic up, dn, rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit last_fall = 1'b0;
  bit tog = 1'b0;

  bbpd_swap u_bbpd_swap (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .swap_mode(swap_mode),
    .up(up), .dn(dn), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) last_fall = sdata;

  // Behavioural reference: sample histories per edge, decision one edge later
  initial begin
    bit rise_q[$];
    bit fall_q[$];
    bit m_mode;
    int blank;
    bit e_up, e_dn, e_rd, p, b, c, s, m, lf, chg;
    string tag;
    rise_q = '{1'b0, 1'b0};
    fall_q = '{1'b0, 1'b0};
    m_mode = 1'b0;
    blank = 0;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      s = sdata; m = swap_mode; lf = last_fall;
      if (!m_mode) begin p = rise_q[$-1]; b = fall_q[$]; c = rise_q[$]; end
      else         begin p = fall_q[$-1]; b = rise_q[$-1]; c = fall_q[$]; end
      chg = (m != m_mode);
      e_rd = c;
      e_up = !chg && blank == 0 && p != c && b == p;
      e_dn = !chg && blank == 0 && p != c && b == c;
      if (chg || blank != 0) tag = "R8";
      else if (p == c) tag = "R3";
      else if (b == p) tag = "R4";
      else tag = "R5";
      blank = chg ? 1 : (blank > 0 ? blank - 1 : 0);
      m_mode = m;
      rise_q.push_back(s);
      fall_q.push_back(lf);
      if (rise_q.size() > 4) void'(rise_q.pop_front());
      if (fall_q.size() > 4) void'(fall_q.pop_front());
      #2;
      check(up, e_up, tag, "up");
      check(dn, e_dn, tag, "dn");
      check(rdata, e_rd, swap_mode ? "R7" : "R2", "rdata");
      check(up && dn, 1'b0, "R6", "up&dn");
    end
  end

  // One clock: next falling sample nf, next rising sample nr
  task automatic half(input bit nf, input bit nr);
    @(posedge clk); #1 sdata = nf;
    @(negedge clk); #1 sdata = nr;
  endtask

  task automatic run_const(input int n);
    for (int i = 0; i < n; i++) half(1'b0, 1'b0);
  endtask
  task automatic run_late(input int n);   // boundary equals new bit
    for (int i = 0; i < n; i++) begin tog = ~tog; half(tog, tog); end
  endtask
  task automatic run_early(input int n);  // boundary equals old bit
    for (int i = 0; i < n; i++) begin half(tog, ~tog); tog = ~tog; end
  endtask
  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      bit a, c;
      a = 1'($urandom); c = 1'($urandom);
      half(a, c);
      tog = c;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      check(up, 1'b0, "R1", "up in reset");
      check(dn, 1'b0, "R1", "dn in reset");
      check(rdata, 1'b0, "R1", "rdata in reset");
    end
    @(posedge clk); #1 rst_n = 1'b1;
    run_const(16);   // R3
    run_late(20);    // R5 in normal mode
    run_early(20);   // R4 in normal mode
    run_rand(40);    // R2
    swap_mode = 1'b1;
    run_late(20);    // R7: same waveform reads as early
    run_early(20);
    run_rand(40);
    swap_mode = 1'b0;
    run_rand(30);    // R8
    swap_mode = 1'b1;
    run_rand(3);
    swap_mode = 1'b0;
    run_rand(1);
    swap_mode = 1'b1;
    run_rand(40);
    swap_mode = 1'b0;
    run_rand(20);
    @(posedge clk); #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule